// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the input pins of one general-purpose I/O port and turns pin activity into a single port interrupt. Each pin has its own two-bit sense code that chooses between a rising edge, a falling edge, a high level and a low level. A pin's input is first brought into the clock domain through a two-stage synchroniser. A detected event then sets that pin's bit in a sticky status register. Software clears a status bit by writing a 1 to it. A mask register decides which status bits may drive the combined interrupt line.

A pin takes part in detection only when its in-use bit is set and its direction bit marks it as an input. Every register sits behind a plain 32-bit word interface. Writes take effect on the clock edge, and the read data is a combinational function of the word address.

Top module: `gpio_port_irq`

## Requirements
- R1: After a synchronous reset, every register reads 0 (all sense codes, in-use, direction, mask and status), and `irq_o` is low.
- R2: Register word addresses: 0 holds sense codes for pins 0 to 15, 1 holds those for pins 16 to 31, 2 is in-use, 3 is direction, 4 is mask and 5 is status. Pin n's code sits in bits [2*(n%16)+1 : 2*(n%16)] of its word. Every configuration word reads back exactly what was written.
- R3: Code 0 (rising edge): a 0-to-1 change on an active pin sets its status bit no later than the third clock edge after the change. A steady high level sets nothing further.
- R4: Code 1 (falling edge): a 1-to-0 change on an active pin sets its status bit. A 0-to-1 change does not.
- R5: Code 2 (high level): the status bit is set on every cycle in which the synchronised pin is high. Once the pin is low, a clear removes the bit for good.
- R6: Code 3 (low level): the status bit is set on every cycle in which the synchronised pin is low. It can be cleared for good once the pin is high.
- R7: Writing to status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a new event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when some status bit is set and its mask bit is 1. A set status bit whose mask bit is 0 does not raise `irq_o`.
- R10: A pin is active only when its in-use bit is 1 and its direction bit is 0 (1 means output). An inactive pin never sets its status bit.
- R11: Changing a pin's sense code, or making a pin active, does not create an event from a pin level that has not changed since earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The bench builds the block with its default parameters: 32 pins, a 32-bit register word and two synchroniser stages. These values make both sense words live, so pins on each side of the word split (0, 3, 8 and 17, 20) are each given their own code. All four codes are exercised, and the two-stage latency can be seen at the ports. With this pin count, the in-use and direction gating and the code-switching case can be tried on separate pins while other pins hold level events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int CODE_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        SENSE_RISE = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_SENSE_LO = 3'd0,
        RA_SENSE_HI = 3'd1,
        RA_INUSE    = 3'd2,
        RA_DIR      = 3'd3,
        RA_MASK     = 3'd4,
        RA_STATUS   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    function automatic logic sense_hit(sense_e code, pin_hist_t h);
        case (code)
            SENSE_RISE: return  h.cur && !h.prev;
            SENSE_FALL: return !h.cur &&  h.prev;
            SENSE_HIGH: return  h.cur;
            default:    return !h.cur;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_sense_det.sv
module gpio_sense_det
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_s,
    input  logic [DATA_W-1:0] sense_lo,
    input  logic [DATA_W-1:0] sense_hi,
    input  logic [NPINS-1:0]  active,
    output logic [NPINS-1:0]  evt
);
    localparam int PER_WORD = DATA_W / CODE_W;

    logic [NPINS-1:0] prev_q;

    // previous value follows the pin whatever the code or activity
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_s;
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        localparam int WSEL = n / PER_WORD;
        localparam int LSB  = CODE_W * (n % PER_WORD);
        sense_e    code;
        pin_hist_t hist;

        if (WSEL == 0) begin : g_lo
            assign code = sense_e'(sense_lo[LSB +: CODE_W]);
        end else begin : g_hi
            assign code = sense_e'(sense_hi[LSB +: CODE_W]);
        end

        assign hist   = '{cur: pin_s[n], prev: prev_q[n]};
        assign evt[n] = active[n] && sense_hit(code, hist);

        // R3
        rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
            (active[n] && code == SENSE_RISE && pin_s[n] && !prev_q[n]) |-> evt[n]);
        // R4
        fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (code == SENSE_FALL && pin_s[n]) |-> !evt[n]);
        // R5
        level_high_chk: assert property (@(posedge clk) disable iff (rst)
            (active[n] && code == SENSE_HIGH && pin_s[n]) |-> evt[n]);
        // R6
        level_low_chk: assert property (@(posedge clk) disable iff (rst)
            (active[n] && code == SENSE_LOW && !pin_s[n]) |-> evt[n]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  evt,
    output logic [DATA_W-1:0] sense_lo,
    output logic [DATA_W-1:0] sense_hi,
    output logic [NPINS-1:0]  active,
    output logic              irq_o
);
    reg_addr_e        addr;
    logic [DATA_W-1:0] sense_q [2];
    logic [NPINS-1:0] inuse_q, dir_q, mask_q, status_q, w1c;
    logic             mask_wr;

    assign addr    = reg_addr_e'(reg_addr);
    assign w1c     = (reg_wr && addr == RA_STATUS) ? reg_wdata[NPINS-1:0] : '0;
    assign mask_wr = reg_wr && addr == RA_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q[0] <= '0;
            sense_q[1] <= '0;
            inuse_q    <= '0;
            dir_q      <= '0;
            mask_q     <= '0;
            status_q   <= '0;
        end else begin
            if (reg_wr) begin
                case (addr)
                    RA_SENSE_LO: sense_q[0] <= reg_wdata;
                    RA_SENSE_HI: sense_q[1] <= reg_wdata;
                    RA_INUSE:    inuse_q    <= reg_wdata[NPINS-1:0];
                    RA_DIR:      dir_q      <= reg_wdata[NPINS-1:0];
                    RA_MASK:     mask_q     <= reg_wdata[NPINS-1:0];
                    default:     ;
                endcase
            end
            // new events override a simultaneous clear
            status_q <= (status_q & ~w1c) | evt;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_SENSE_LO: reg_rdata = sense_q[0];
            RA_SENSE_HI: reg_rdata = sense_q[1];
            RA_INUSE:    reg_rdata[NPINS-1:0] = inuse_q;
            RA_DIR:      reg_rdata[NPINS-1:0] = dir_q;
            RA_MASK:     reg_rdata[NPINS-1:0] = mask_q;
            RA_STATUS:   reg_rdata[NPINS-1:0] = status_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign sense_lo = sense_q[0];
    assign sense_hi = sense_q[1];
    assign active   = inuse_q & ~dir_q;
    assign irq_o    = |(status_q & mask_q);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && status_q == '0 && !irq_o));
    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (w1c != '0) |=> ((status_q & $past(w1c & ~evt)) == '0));
    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(evt & mask_q)) && !mask_wr) |=> irq_o);
    // R10
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(active)) == '0));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [NPINS-1:0]  pin_s, evt, active;
    logic [DATA_W-1:0] sense_lo, sense_hi;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_s)
    );

    gpio_sense_det #(.NPINS(NPINS)) u_det (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (pin_s),
        .sense_lo (sense_lo),
        .sense_hi (sense_hi),
        .active   (active),
        .evt      (evt)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .sense_lo  (sense_lo),
        .sense_hi  (sense_hi),
        .active    (active),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/gpio_port_irq_test.sv
`timescale 1ns/1ps
module gpio_port_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_i = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] s_lo = '0, s_hi = '0;

    localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_USE = 3'd2,
                           A_DIR = 3'd3, A_MASK = 3'd4, A_STAT = 3'd5;

    always #2 clk = ~clk;

    gpio_port_irq uut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_code(input int pin, input logic [1:0] code);
        if (pin < 16) begin
            s_lo[2*pin +: 2] = code;
            wr(A_LO, s_lo);
        end else begin
            s_hi[2*(pin-16) +: 2] = code;
            wr(A_HI, s_hi);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(A_USE, 32'hFFFF_FFFF);
        wr(A_DIR, 32'h0);
        rd(A_USE, d); chk("R2 in-use readback", d, 32'hFFFF_FFFF);
        rd(A_DIR, d); chk("R2 dir readback", d, 32'h0);
        settle();
        rd(A_STAT, d); chk("R2 no event on enable", d, 32'h0);
    endtask

    task automatic t_rise_mask_w1c();
        logic [31:0] d;
        pin_i[3] = 1'b1;
        @(negedge clk); rd(A_STAT, d);
        chk("R3 not before sync", d & 32'h8, 32'h0);
        settle();
        rd(A_STAT, d); chk("R3 rising sets bit3", d, 32'h8);
        chk("R9 masked stays low", {31'h0, irq_o}, 32'h0);
        wr(A_MASK, 32'h8);
        @(negedge clk); chk("R9 unmasked raises irq", {31'h0, irq_o}, 32'h1);
        settle();
        rd(A_STAT, d); chk("R3 steady high no repeat", d, 32'h8);
        wr(A_STAT, 32'hFFFF_FFF7);
        rd(A_STAT, d); chk("R7 zero bit keeps", d, 32'h8);
        wr(A_STAT, 32'h8);
        rd(A_STAT, d); chk("R7 one bit clears", d, 32'h0);
        chk("R9 irq drops", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        set_code(20, 2'd1);
        rd(A_HI, d); chk("R2 sense hi readback", d, 32'h0000_0100);
        pin_i[20] = 1'b1; settle();
        rd(A_STAT, d); chk("R4 rise ignored", d & (32'h1 << 20), 32'h0);
        pin_i[20] = 1'b0; settle();
        rd(A_STAT, d); chk("R4 fall sets", d & (32'h1 << 20), 32'h1 << 20);
        wr(A_STAT, 32'h1 << 20);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        set_code(17, 2'd2);
        settle(); rd(A_STAT, d); chk("R5 low no event", d & (32'h1 << 17), 32'h0);
        pin_i[17] = 1'b1; settle();
        rd(A_STAT, d); chk("R5 high sets", d & (32'h1 << 17), 32'h1 << 17);
        wr(A_STAT, 32'h1 << 17);
        rd(A_STAT, d); chk("R8 clear during level loses", d & (32'h1 << 17), 32'h1 << 17);
        pin_i[17] = 1'b0; settle();
        wr(A_STAT, 32'h1 << 17); settle();
        rd(A_STAT, d); chk("R5 clear after level gone", d & (32'h1 << 17), 32'h0);
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        set_code(0, 2'd3);
        rd(A_LO, d); chk("R2 sense lo readback", d, 32'h3);
        settle(); rd(A_STAT, d); chk("R6 low sets", d & 32'h1, 32'h1);
        pin_i[0] = 1'b1; settle();
        wr(A_STAT, 32'h1); settle();
        rd(A_STAT, d); chk("R6 clear sticks when high", d & 32'h1, 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        wr(A_USE, 32'hFFFF_FFDF);
        wr(A_DIR, 32'h0000_0040);
        pin_i[5] = 1'b1; pin_i[6] = 1'b1; settle();
        rd(A_STAT, d); chk("R10 unused and output pins quiet", d & 32'h60, 32'h0);
        wr(A_USE, 32'hFFFF_FFFF);
        wr(A_DIR, 32'h0); settle();
        rd(A_STAT, d); chk("R11 enable on steady high no event", d & 32'h60, 32'h0);
    endtask

    task automatic t_code_switch();
        logic [31:0] d;
        set_code(8, 2'd1);
        pin_i[8] = 1'b1; settle();
        rd(A_STAT, d); chk("R11 falling code, rising pin quiet", d & 32'h100, 32'h0);
        set_code(8, 2'd0); settle();
        rd(A_STAT, d); chk("R11 switch to rising no false edge", d & 32'h100, 32'h0);
        set_code(8, 2'd2); settle();
        rd(A_STAT, d); chk("R5 switch to high level sets", d & 32'h100, 32'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_rise_mask_w1c();
        t_fall();
        t_level_high();
        t_level_low();
        t_gating();
        t_code_switch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule